// File: doc/BRIEF.md
# Command Port Register Access Sequencer

This block sits on the host side of an attached USB peripheral. It reaches the peripheral's internal register bank through a single 8-bit command port. It uses separate asynchronous read, write and output-enable strobes, and it never shares a clock with the peripheral. A user asks for one register operation at a time with `reqValid`, supplying the direction, a 6-bit register index and, for writes, a byte. The sequencer turns that request into a short series of indirect command-port transfers. It returns read data on `rdData` and marks completion with a one-cycle `done`.

No register is addressed directly. Each operation opens with an address word that names the register and the direction. A write then sends the byte as two nibble words, high nibble first. A read follows the address word with one read transfer that returns the full byte. The peripheral may stall any transfer by holding `readyIn` low, and the sequencer sits in a waiting state until it is released. Strobe width and the setup and hold margins around each strobe are counted in clock cycles and set by parameters.

Top module: `cmdport_seq`

## Requirements
- R1: `portSel` always presents the command-port code 3'b100 and never any other value, including during every strobe.
- R2: A write request produces exactly three write transfers and no read transfer. The words are `{1'b1, 1'b0, addr[5:0]}`, then `{4'b0000, data[7:4]}`, then `{4'b0000, data[3:0]}`.
- R3: A read request produces one write transfer carrying `{1'b1, 1'b1, addr[5:0]}`, followed by one read transfer. `rdData` takes the `busIn` value present while `oeN` is low and keeps it until the next read completes; writes leave it untouched.
- R4: Every write or read strobe stays low for exactly STROBE_CYC cycles. During a write strobe `busDrive` is high and `busOut` does not change.
- R5: A transfer begins only after `readyIn` is sampled high. While `readyIn` is held low, no strobe is asserted. Once `readyIn` rises, the remaining transfers proceed with no extra delay.
- R6: On a read transfer `rdN` and `oeN` are low together and `busDrive` is low. The read and write strobes are never low at the same time.
- R7: A request is taken when `reqValid` is high and `busy` is low at a clock edge. `busy` is high from the next cycle until completion.
- R8: A `reqValid` pulse that arrives while `busy` is high is ignored. It changes neither the running operation's words nor any register in the peripheral.
- R9: `done` is high for exactly one cycle per operation, and `busy` is low in that cycle. A request presented during that cycle is accepted and runs normally.
- R10: With `readyIn` held high, each transfer takes 1+SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. `done` rises three transfer times after the accepting edge for a write and two transfer times after it for a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqRead | input | 1 | 1 = register read, 0 = register write |
| reqAddr | input | 6 | Register index (0 to 63) |
| reqWdata | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte returned by the last read |
| readyIn | input | 1 | Peripheral ready to accept the next transfer |
| portSel | output | 3 | Port-select address, fixed to the command port |
| busOut | output | 8 | Data driven toward the peripheral |
| busDrive | output | 1 | High while busOut should be driven onto the bus |
| busIn | input | 8 | Data returned by the peripheral |
| wrN | output | 1 | Active-low write strobe |
| rdN | output | 1 | Active-low read strobe |
| oeN | output | 1 | Active-low output enable for the peripheral |

## Verification
The completion pulse of one operation and the acceptance of the next one can fall in the same cycle, because `busy` is already low while `done` is high. The bench provokes this by raising `reqValid` with a read in the very cycle it observes `done` from a write. It then judges the chained read by its latency, by its address word and by the byte it returns, which must be the one just written. A second overlap, a request arriving mid-operation, is provoked by a stray `reqValid` pulse. It is judged by the word stream of the running write and by reading back the register the stray pulse named.

// File: rtl/cmdport_pkg.sv
package cmdport_pkg;
  localparam int unsigned SUBADDR_W = 6;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NIBBLE_W  = 4;
  localparam logic [2:0]  CMD_PORT_SEL = 3'b100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } seqState_t;

  typedef enum logic [1:0] {
    W_ADDR = 2'd0,
    W_HI   = 2'd1,
    W_LO   = 2'd2
  } wordSel_t;

  typedef struct packed {
    logic     load;
    logic     drive;
    logic     wrStb;
    logic     rdStb;
    logic     capture;
    logic     doneSet;
    wordSel_t wordSel;
  } seqCtl_t;
endpackage

// File: rtl/cmdport_ctrl.sv
module cmdport_ctrl
  import cmdport_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqRead,
  input  logic    readyIn,
  output seqCtl_t ctl,
  output logic    busy
);
  localparam int unsigned MAX_SH  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int unsigned MAX_CYC = (MAX_SH > STROBE_CYC) ? MAX_SH : STROBE_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       xferIdx;
  logic             opRead;
  logic             curRd;
  logic             lastXfer;
  logic             cntZero;

  // Transfer 1 of a read is the only read-direction transfer.
  assign curRd    = opRead && (xferIdx == 2'd1);
  assign lastXfer = opRead ? (xferIdx == 2'd1) : (xferIdx == 2'd2);
  assign cntZero  = (cnt == '0);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.wordSel = wordSel_t'(xferIdx);
    unique case (state)
      ST_IDLE:   ctl.load = reqValid;
      ST_WAIT:   ;
      ST_SETUP:  ctl.drive = !curRd;
      ST_STROBE: begin
        ctl.drive = !curRd;
        ctl.wrStb = !curRd;
        ctl.rdStb = curRd;
      end
      ST_HOLD: begin
        ctl.drive   = !curRd;
        ctl.capture = curRd && (cnt == HOLD_LD);
        ctl.doneSet = cntZero && lastXfer;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      xferIdx <= 2'd0;
      opRead  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          opRead  <= reqRead;
          xferIdx <= 2'd0;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (readyIn) begin
          cnt   <= SETUP_LD;
          state <= ST_SETUP;
        end
        ST_SETUP: if (cntZero) begin
          cnt   <= STROBE_LD;
          state <= ST_STROBE;
        end else cnt <= cnt - 1'b1;
        ST_STROBE: if (cntZero) begin
          cnt   <= HOLD_LD;
          state <= ST_HOLD;
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cntZero) begin
          if (lastXfer) state <= ST_IDLE;
          else begin
            xferIdx <= xferIdx + 2'd1;
            state   <= ST_WAIT;
          end
        end else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_FOR_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !readyIn) |=> (state == ST_WAIT)); // R5
  AST_XFER_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (xferIdx <= (opRead ? 2'd1 : 2'd2))); // R2
endmodule

// File: rtl/cmdport_dp.sv
module cmdport_dp
  import cmdport_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic                 reqRead,
  input  logic [SUBADDR_W-1:0] reqAddr,
  input  logic [BYTE_W-1:0]    reqWdata,
  input  logic [BYTE_W-1:0]    busIn,
  output logic [BYTE_W-1:0]    busOut,
  output logic                 busDrive,
  output logic                 wrN,
  output logic                 rdN,
  output logic                 oeN,
  output logic                 done,
  output logic [BYTE_W-1:0]    rdData
);
  logic [SUBADDR_W-1:0] addrQ;
  logic [BYTE_W-1:0]    dataQ;
  logic                 rdQ;
  logic [BYTE_W-1:0]    word;

  always_comb begin
    unique case (ctl.wordSel)
      W_ADDR:  word = {1'b1, rdQ, addrQ};
      W_HI:    word = {{(BYTE_W-NIBBLE_W){1'b0}}, dataQ[BYTE_W-1 -: NIBBLE_W]};
      W_LO:    word = {{(BYTE_W-NIBBLE_W){1'b0}}, dataQ[NIBBLE_W-1:0]};
      default: word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      rdQ   <= 1'b0;
    end else if (ctl.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      rdQ   <= reqRead;
    end
  end

  // Pin-facing registers keep the asynchronous strobes free of decode glitches.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOut   <= '0;
      busDrive <= 1'b0;
      wrN      <= 1'b1;
      rdN      <= 1'b1;
      oeN      <= 1'b1;
      done     <= 1'b0;
      rdData   <= '0;
    end else begin
      if (ctl.drive) busOut <= word;
      busDrive <= ctl.drive;
      wrN      <= !ctl.wrStb;
      rdN      <= !ctl.rdStb;
      oeN      <= !ctl.rdStb;
      done     <= ctl.doneSet;
      if (ctl.capture) rdData <= busIn;
    end
  end

  AST_CAPTURE_UNDER_OE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !oeN); // R3
endmodule

// File: rtl/cmdport_seq.sv
module cmdport_seq
  import cmdport_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqRead,
  input  logic [5:0] reqAddr,
  input  logic [7:0] reqWdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdData,
  input  logic       readyIn,
  output logic [2:0] portSel,
  output logic [7:0] busOut,
  output logic       busDrive,
  input  logic [7:0] busIn,
  output logic       wrN,
  output logic       rdN,
  output logic       oeN
);
  seqCtl_t ctl;

  assign portSel = CMD_PORT_SEL;

  cmdport_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqRead (reqRead),
    .readyIn (readyIn),
    .ctl     (ctl),
    .busy    (busy)
  );

  cmdport_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqRead (reqRead),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .busIn   (busIn),
    .busOut  (busOut),
    .busDrive(busDrive),
    .wrN     (wrN),
    .rdN     (rdN),
    .oeN     (oeN),
    .done    (done),
    .rdData  (rdData)
  );

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!wrN && !rdN)); // R6
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !busDrive); // R6
  AST_WRITE_BUS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && $past(!wrN)) |-> $stable(busOut)); // R4
  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busDrive); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
endmodule

// File: tb/cmdport_seq_test.sv
module cmdport_seq_test;
  localparam int S_CYC = 1;
  localparam int T_CYC = 2;
  localparam int H_CYC = 1;
  localparam int XFER  = 1 + S_CYC + T_CYC + H_CYC;
  localparam int NREG  = 37;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqRead = 1'b0;
  logic [5:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic       readyIn = 1'b1;
  logic [7:0] busIn;
  logic       busy, done, busDrive, wrN, rdN, oeN;
  logic [7:0] rdData, busOut;
  logic [2:0] portSel;

  int nChecks = 0;
  int nErrors = 0;

  logic [7:0] wordLog [8];
  int         wordCnt = 0;
  int         rdCnt = 0;
  int         wrRun = 0;
  int         rdRun = 0;
  bit         noStrobe = 1'b0;
  logic [7:0] periph [64];
  logic [5:0] pAddr = '0;
  logic [3:0] pHi = '0;
  bit         pNib = 1'b0;

  always #2.5 clk = ~clk;

  cmdport_seq #(.SETUP_CYC(S_CYC), .STROBE_CYC(T_CYC), .HOLD_CYC(H_CYC)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdData(rdData), .readyIn(readyIn), .portSel(portSel), .busOut(busOut),
    .busDrive(busDrive), .busIn(busIn), .wrN(wrN), .rdN(rdN), .oeN(oeN)
  );

  // Peripheral model: returns the addressed register while output enable is low.
  assign busIn = !oeN ? periph[pAddr] : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 29 + 7) & 8'hFF);
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (noStrobe) chk(wrN && rdN, "R5 strobe while not ready", {30'd0, wrN, rdN}, 3);
      if (!wrN) begin
        if (wrRun == 0) begin
          if (wordCnt < 8) wordLog[wordCnt] = busOut;
          wordCnt++;
          if (busOut[7]) begin
            pAddr = busOut[5:0];
            pNib  = 1'b0;
          end else if (!pNib) begin
            pHi  = busOut[3:0];
            pNib = 1'b1;
          end else begin
            periph[pAddr] = {pHi, busOut[3:0]};
            pNib = 1'b0;
          end
        end
        chk(portSel == 3'b100, "R1 portSel on write", int'(portSel), 4);
        chk(busDrive, "R4 busDrive during write strobe", int'(busDrive), 1);
        wrRun++;
      end else if (wrRun != 0) begin
        chk(wrRun == T_CYC, "R4 write strobe width", wrRun, T_CYC);
        wrRun = 0;
      end
      if (!rdN) begin
        if (rdRun == 0) rdCnt++;
        chk(!oeN, "R6 oeN with rdN", int'(oeN), 0);
        chk(!busDrive, "R6 bus released on read", int'(busDrive), 0);
        chk(portSel == 3'b100, "R1 portSel on read", int'(portSel), 4);
        rdRun++;
      end else if (rdRun != 0) begin
        chk(rdRun == T_CYC, "R4 read strobe width", rdRun, T_CYC);
        rdRun = 0;
      end
    end
  end

  // Caller stands at a negative edge.
  task automatic startReq(input bit rd, input logic [5:0] a, input logic [7:0] wd);
    reqValid = 1'b1;
    reqRead  = rd;
    reqAddr  = a;
    reqWdata = wd;
    wordCnt  = 0;
    rdCnt    = 0;
  endtask

  task automatic waitDone(output int lat, input bit poke);
    lat = 0;
    while (!done && lat < 1000) begin
      if (poke && lat == 2) begin
        reqValid = 1'b1;
        reqRead  = ~reqRead;
        reqAddr  = 6'd12;
        reqWdata = 8'h99;
      end
      if (poke && lat == 3) reqValid = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    if (lat >= 1000) chk(1'b0, "R9 done never seen", lat, 0);
  endtask

  task automatic finishReq(output int lat, input bit poke);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R7 busy after accept", int'(busy), 1);
    waitDone(lat, poke);
  endtask

  task automatic chkWrite(input logic [5:0] a, input logic [7:0] wd);
    chk(wordCnt == 3, "R2 write transfer count", wordCnt, 3);
    chk(rdCnt == 0, "R2 no read transfer on write", rdCnt, 0);
    chk(wordLog[0] == {2'b10, a}, "R2 address word", int'(wordLog[0]), int'({2'b10, a}));
    chk(wordLog[1] == {4'h0, wd[7:4]}, "R2 high nibble word", int'(wordLog[1]), int'({4'h0, wd[7:4]}));
    chk(wordLog[2] == {4'h0, wd[3:0]}, "R2 low nibble word", int'(wordLog[2]), int'({4'h0, wd[3:0]}));
  endtask

  task automatic chkRead(input logic [5:0] a, input logic [7:0] exp);
    chk(wordCnt == 1, "R3 read command word count", wordCnt, 1);
    chk(wordLog[0] == {2'b11, a}, "R3 read command word", int'(wordLog[0]), int'({2'b11, a}));
    chk(rdCnt == 1, "R3 read transfer count", rdCnt, 1);
    chk(rdData == exp, "R3 read data", int'(rdData), int'(exp));
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    int lat;
    for (int i = 0; i < 64; i++) periph[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R7 R9 idle after reset", {30'd0, busy, done}, 0);
    chk(wrN && rdN && oeN && !busDrive, "R6 strobes idle after reset",
        {28'd0, wrN, rdN, oeN, busDrive}, 4'b1110);
    chk(portSel == 3'b100, "R1 portSel after reset", int'(portSel), 4);
    chk(rdData == 8'h00, "R3 rdData after reset", int'(rdData), 0);

    for (int a = 0; a < NREG; a++) begin
      startReq(1'b0, 6'(a), pattern(a));
      finishReq(lat, 1'b0);
      chk(lat == 3 * XFER, "R10 write latency", lat, 3 * XFER);
      chkWrite(6'(a), pattern(a));
    end
    chk(rdData == 8'h00, "R3 writes leave rdData", int'(rdData), 0);

    for (int a = 0; a < NREG; a++) begin
      startReq(1'b1, 6'(a), 8'h5A);
      finishReq(lat, 1'b0);
      chk(lat == 2 * XFER, "R10 read latency", lat, 2 * XFER);
      chkRead(6'(a), pattern(a));
    end
    @(negedge clk);
    chk(!done, "R9 done lasts one cycle", int'(done), 0);

    // R8: a stray request during a write must be ignored.
    startReq(1'b0, 6'd40, 8'hC3);
    finishReq(lat, 1'b1);
    chk(lat == 3 * XFER, "R8 latency with stray request", lat, 3 * XFER);
    chkWrite(6'd40, 8'hC3);
    @(negedge clk);
    chk(!busy, "R8 stray request not started", int'(busy), 0);
    startReq(1'b1, 6'd12, 8'h00);
    finishReq(lat, 1'b0);
    chkRead(6'd12, pattern(12));

    // R9: chain a read in the completion cycle of a write.
    startReq(1'b0, 6'd50, 8'h3C);
    finishReq(lat, 1'b0);
    chk(!busy, "R9 busy low with done", int'(busy), 0);
    startReq(1'b1, 6'd50, 8'h00);
    finishReq(lat, 1'b0);
    chk(lat == 2 * XFER, "R9 chained read latency", lat, 2 * XFER);
    chkRead(6'd50, 8'h3C);

    // R5: hold ready low before the first transfer.
    readyIn = 1'b0;
    startReq(1'b0, 6'd20, 8'hE1);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    noStrobe = 1'b1;
    repeat (20) @(negedge clk);
    noStrobe = 1'b0;
    chk(wordCnt == 0, "R5 no transfer while not ready", wordCnt, 0);
    readyIn = 1'b1;
    waitDone(lat, 1'b0);
    chk(lat == 3 * XFER, "R5 prompt resume after ready", lat, 3 * XFER);
    chkWrite(6'd20, 8'hE1);
    startReq(1'b1, 6'd20, 8'h00);
    finishReq(lat, 1'b0);
    chkRead(6'd20, 8'hE1);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule